// File: doc/BRIEF.md
# Mailbox Message Queue Slot Array

This block carries whole messages between a host-side register bus and a CPU-side register bus. It holds a parameterised number of incoming slots, where the host produces and the CPU consumes, and outgoing slots, where the CPU produces and the host consumes. Every slot is a ring of fixed-size entries. A producer first claims an entry, then fills payload words through a data window, and finally commits the entry with one command write that also carries the message length in words. The consumer reads the head message through its own data window and drops it with a discard command, which moves the head to the next message.

Each slot has a status word that both buses can read. It packs the full and empty flags, the slot geometry as base-2 logarithms, the number of occupied entries and the length of the head message. A purge command, accepted from either side, empties a slot at once. A global region on offset zero reports how many slots of each direction exist. It also gathers one flag per slot into a single status word: empty for an incoming slot, not-empty for an outgoing slot. A mask register uses the same bit layout, and the interrupt output is the OR of the masked flags.

Both buses are simple single-cycle request ports. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the request.

Top module: `mq_mailbox`

## Requirements
- R1: After reset every slot is empty: status bit 1 is set, bit 0 and the count and head-length fields are zero, and the geometry fields hold the parameters. The interrupt output is low.
- R2: A CLAIM (command bit 24) followed by payload writes to data word i (slot offset 8+4*i) and a READY (bit 26) that carries the length in bits [7:0] makes the message visible at the next clock edge. The occupied count rises by one in that same cycle, and the consumer reads the payload words back unchanged.
- R3: The slot status word has these fields: bit 0 full, bit 1 empty, [7:2] log2 of the entry count, [15:8] occupied entries, [23:16] length of the head message (0 when empty), [31:28] log2 of the words per entry. All other bits read 0.
- R4: A READY with no CLAIM pending since the last READY or PURGE is ignored. A CLAIM on a full slot is ignored, so a READY after it changes nothing.
- R5: DISCARD (bit 27) on the consumer side drops the head message, and messages leave in the order they were committed. DISCARD on an empty slot has no effect.
- R6: PURGE (bit 25) from either side sets the count to zero and drops any pending claim. It wins over a READY or DISCARD in the same write.
- R7: Incoming slot s is at 0x4000+s*0x400 and outgoing slot s at 0x8000+s*0x400, with the command at offset 0 and the status at offset 4. CLAIM and READY are accepted only from the producer side and DISCARD only from the consumer side. Status reads work from both sides.
- R8: Global word 0x0 reads the incoming slot count in [7:0] and the outgoing slot count in [15:8].
- R9: Global word 0x4 reads the not-empty flag of outgoing slot s in bit s and the empty flag of incoming slot s in bit 16+s.
- R10: Global word 0x8 is a read/write interrupt mask in the same layout as 0x4, restricted to bits of existing slots. The interrupt output equals the OR over (status AND mask) in every cycle.
- R11: Read data for a request appears on the side's read-data port one clock after the request and then holds.
- R12: A slot accepts exactly 2^ENTRIES_LOG2 messages before it sets the full flag. Its pointers wrap, so messages committed after a full drain are delivered intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host bus request |
| hst_we | input | 1 | Host bus write enable |
| hst_addr | input | 16 | Host bus byte address |
| hst_wdata | input | 32 | Host bus write data |
| hst_rdata | output | 32 | Host bus read data, registered |
| cpu_req | input | 1 | CPU bus request |
| cpu_we | input | 1 | CPU bus write enable |
| cpu_addr | input | 16 | CPU bus byte address |
| cpu_wdata | input | 32 | CPU bus write data |
| cpu_rdata | output | 32 | CPU bus read data, registered |
| irq_o | output | 1 | Masked slot-flag interrupt |

## Verification
The bench builds the block with two incoming and two outgoing slots, four entries per slot and eight words per entry. With four entries, the full flag, a CLAIM refused on a full slot, and pointer wrap-around can all be reached within a few dozen bus operations. With two slots in each direction, the slot-index decode and both halves of the global status and mask words are exercised, including bits that belong to missing slots.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int ADDR_W          = 16;
    localparam int WORD_W          = 32;
    localparam int LEN_W           = 8;
    localparam int CMD_CLAIM_BIT   = 24;
    localparam int CMD_PURGE_BIT   = 25;
    localparam int CMD_READY_BIT   = 26;
    localparam int CMD_DISCARD_BIT = 27;

    typedef enum logic [1:0] {
        RGN_GLOBAL = 2'd0,
        RGN_IN     = 2'd1,
        RGN_OUT    = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        FLD_CMD  = 2'd0,
        FLD_STAT = 2'd1,
        FLD_DATA = 2'd2
    } field_e;

    typedef struct packed {
        region_e    rgn;
        logic [3:0] slot;
        field_e     fld;
        logic [7:0] widx;
        logic [1:0] greg;
        logic       gok;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.rgn  = region_e'(a[15:14]);
        d.slot = a[13:10];
        d.widx = a[9:2] - 8'd2;
        d.greg = a[3:2];
        d.gok  = (a[13:4] == '0);
        if (a[9:2] == 8'd0)      d.fld = FLD_CMD;
        else if (a[9:2] == 8'd1) d.fld = FLD_STAT;
        else                     d.fld = FLD_DATA;
        return d;
    endfunction
endpackage

// File: rtl/mq_slot.sv
module mq_slot #(
    parameter int ENTRIES_LOG2 = 3,
    parameter int WORDS_LOG2   = 3,
    parameter int DATA_W       = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  claim_i,
    input  logic                  commit_i,
    input  logic [7:0]            len_i,
    input  logic                  discard_i,
    input  logic                  purge_i,
    input  logic                  wr_en_i,
    input  logic [WORDS_LOG2-1:0] wr_idx_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [WORDS_LOG2-1:0] rd_idx_i,
    output logic [DATA_W-1:0]     rd_word_o,
    output logic [31:0]           status_o,
    output logic                  empty_o
);
    localparam int ENTRIES = 1 << ENTRIES_LOG2;
    localparam int WORDS   = 1 << WORDS_LOG2;
    localparam int DEPTH   = ENTRIES * WORDS;
    localparam int CNT_W   = ENTRIES_LOG2 + 1;

    typedef struct packed {
        logic [ENTRIES_LOG2-1:0] wr_ptr;
        logic [ENTRIES_LOG2-1:0] rd_ptr;
        logic [CNT_W-1:0]        count;
        logic                    claimed;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [7:0]        len_q [ENTRIES];
    logic is_full, is_empty, take_commit, take_discard;

    assign is_full  = (s_q.count == CNT_W'(ENTRIES));
    assign is_empty = (s_q.count == '0);

    always_comb begin
        s_d          = s_q;
        take_commit  = commit_i && s_q.claimed && !is_full;
        take_discard = discard_i && !is_empty;
        if (commit_i)     s_d.claimed = 1'b0;
        if (take_commit)  s_d.wr_ptr  = s_q.wr_ptr + ENTRIES_LOG2'(1);
        if (take_discard) s_d.rd_ptr  = s_q.rd_ptr + ENTRIES_LOG2'(1);
        case ({take_commit, take_discard})
            2'b10:   s_d.count = s_q.count + CNT_W'(1);
            2'b01:   s_d.count = s_q.count - CNT_W'(1);
            default: s_d.count = s_q.count;
        endcase
        if (claim_i && !is_full) s_d.claimed = 1'b1;
        if (purge_i)             s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i && !is_full) mem_q[{s_q.wr_ptr, wr_idx_i}] <= wr_data_i;
        if (take_commit)         len_q[s_q.wr_ptr] <= len_i;
    end

    assign rd_word_o = mem_q[{s_q.rd_ptr, rd_idx_i}];
    assign empty_o   = is_empty;
    assign status_o  = {4'(WORDS_LOG2), 4'b0,
                        (is_empty ? 8'h00 : len_q[s_q.rd_ptr]),
                        8'(s_q.count), 6'(ENTRIES_LOG2), is_empty, is_full};

    // R12: occupancy never exceeds the ring depth
    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(ENTRIES));
    // R6: purge leaves the slot empty
    p_purge_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        purge_i |=> empty_o);
    // R4: ready without a pending claim keeps occupancy
    p_ready_unclaimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !s_q.claimed && !purge_i && !discard_i) |=> $stable(s_q.count));
    // R5: discard on an empty slot leaves it empty
    p_discard_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_i && is_empty && !commit_i && !purge_i) |=> empty_o);
    // R2: accepted commit is counted in the next cycle
    p_commit_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && s_q.claimed && !is_full && !discard_i && !purge_i)
        |=> (s_q.count == $past(s_q.count) + CNT_W'(1)));
endmodule

// File: rtl/mq_global.sv
module mq_global #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_empty_i,
    input  logic [N_OUT-1:0] out_nempty_i,
    input  logic             mask_we_i,
    input  logic [31:0]      mask_wdata_i,
    output logic [31:0]      gstat_o,
    output logic [31:0]      gmask_o,
    output logic             irq_o
);
    localparam logic [31:0] OUT_BITS = 32'((64'd1 << N_OUT) - 64'd1);
    localparam logic [31:0] IN_BITS  = 32'((64'd1 << N_IN) - 64'd1) << 16;
    localparam logic [31:0] VALID    = OUT_BITS | IN_BITS;

    typedef struct packed { logic [31:0] mask; } glob_st_t;
    glob_st_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (mask_we_i) g_d.mask = mask_wdata_i & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gstat_o = 32'(out_nempty_i) | (32'(in_empty_i) << 16);
    assign gmask_o = g_q.mask;
    assign irq_o   = |(gstat_o & g_q.mask);

    // R10: an interrupt needs an enabled mask bit
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (g_q.mask != '0));
    // R10: no raised flag, no interrupt
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gstat_o == '0) |-> !irq_o);
    // R10: mask never holds bits of missing slots
    p_mask_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.mask & ~VALID) == '0);
endmodule

// File: rtl/mq_mailbox.sv
module mq_mailbox
    import mq_pkg::*;
#(
    parameter int N_IN         = 2,
    parameter int N_OUT        = 2,
    parameter int ENTRIES_LOG2 = 3,
    parameter int WORDS_LOG2   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_req,
    input  logic        hst_we,
    input  logic [15:0] hst_addr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        irq_o
);
    localparam int N_TOT = N_IN + N_OUT;
    localparam int WORDS = 1 << WORDS_LOG2;
    localparam logic [31:0] CNT_WORD = {16'b0, 8'(N_OUT), 8'(N_IN)};

    dec_t        sd   [2];
    logic        sreq [2];
    logic        swe  [2];
    logic [31:0] swd  [2];
    logic        widx_ok [2];

    always_comb begin
        sd[0] = decode_addr(hst_addr);  sd[1] = decode_addr(cpu_addr);
        sreq[0] = hst_req;  sreq[1] = cpu_req;
        swe[0]  = hst_we;   swe[1]  = cpu_we;
        swd[0]  = hst_wdata; swd[1] = cpu_wdata;
        for (int s = 0; s < 2; s++) widx_ok[s] = (sd[s].widx < 8'(WORDS));
    end

    logic [31:0]      stat  [N_TOT];
    logic [31:0]      rword [N_TOT];
    logic [N_IN-1:0]  in_empty;
    logic [N_OUT-1:0] out_nempty;

    for (genvar g = 0; g < N_TOT; g++) begin : g_slot
        localparam int         PS = (g < N_IN) ? 0 : 1;
        localparam int         CS = 1 - PS;
        localparam logic [1:0] RG = (g < N_IN) ? 2'd1 : 2'd2;
        localparam logic [3:0] SN = 4'((g < N_IN) ? g : g - N_IN);
        logic p_cmd, c_cmd, p_dat, empty_w;

        assign p_cmd = sreq[PS] && swe[PS] && sd[PS].rgn == region_e'(RG)
                       && sd[PS].slot == SN && sd[PS].fld == FLD_CMD;
        assign c_cmd = sreq[CS] && swe[CS] && sd[CS].rgn == region_e'(RG)
                       && sd[CS].slot == SN && sd[CS].fld == FLD_CMD;
        assign p_dat = sreq[PS] && swe[PS] && sd[PS].rgn == region_e'(RG)
                       && sd[PS].slot == SN && sd[PS].fld == FLD_DATA && widx_ok[PS];

        mq_slot #(
            .ENTRIES_LOG2(ENTRIES_LOG2),
            .WORDS_LOG2  (WORDS_LOG2),
            .DATA_W      (WORD_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim_i  (p_cmd && swd[PS][CMD_CLAIM_BIT]),
            .commit_i (p_cmd && swd[PS][CMD_READY_BIT]),
            .len_i    (swd[PS][LEN_W-1:0]),
            .discard_i(c_cmd && swd[CS][CMD_DISCARD_BIT]),
            .purge_i  ((p_cmd && swd[PS][CMD_PURGE_BIT]) || (c_cmd && swd[CS][CMD_PURGE_BIT])),
            .wr_en_i  (p_dat),
            .wr_idx_i (sd[PS].widx[WORDS_LOG2-1:0]),
            .wr_data_i(swd[PS]),
            .rd_idx_i (sd[CS].widx[WORDS_LOG2-1:0]),
            .rd_word_o(rword[g]),
            .status_o (stat[g]),
            .empty_o  (empty_w)
        );

        if (g < N_IN) begin : g_in
            assign in_empty[g] = empty_w;
        end else begin : g_out
            assign out_nempty[g - N_IN] = !empty_w;
        end
    end

    logic [31:0] gstat, gmask;
    logic        mask_we;
    assign mask_we = sreq[0] && swe[0] && sd[0].rgn == RGN_GLOBAL && sd[0].gok
                     && sd[0].greg == 2'd2;

    mq_global #(.N_IN(N_IN), .N_OUT(N_OUT)) u_global (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_empty_i  (in_empty),
        .out_nempty_i(out_nempty),
        .mask_we_i   (mask_we),
        .mask_wdata_i(hst_wdata),
        .gstat_o     (gstat),
        .gmask_o     (gmask),
        .irq_o       (irq_o)
    );

    typedef struct packed { logic [31:0] rd_h; logic [31:0] rd_c; } rd_st_t;
    rd_st_t      r_d, r_q;
    logic [31:0] rd_val [2];

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            rd_val[s] = '0;
            if (sd[s].rgn == RGN_GLOBAL) begin
                if (sd[s].gok) begin
                    case (sd[s].greg)
                        2'd0:    rd_val[s] = CNT_WORD;
                        2'd1:    rd_val[s] = gstat;
                        2'd2:    rd_val[s] = gmask;
                        default: rd_val[s] = '0;
                    endcase
                end
            end else if (sd[s].rgn != RGN_NONE) begin
                for (int g = 0; g < N_TOT; g++) begin
                    if (sd[s].rgn == ((g < N_IN) ? RGN_IN : RGN_OUT)
                        && sd[s].slot == 4'((g < N_IN) ? g : g - N_IN)) begin
                        if (sd[s].fld == FLD_STAT)
                            rd_val[s] = stat[g];
                        else if (sd[s].fld == FLD_DATA && widx_ok[s]
                                 && s == ((g < N_IN) ? 1 : 0))
                            rd_val[s] = rword[g];
                    end
                end
            end
        end
        r_d = r_q;
        if (hst_req && !hst_we) r_d.rd_h = rd_val[0];
        if (cpu_req && !cpu_we) r_d.rd_c = rd_val[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hst_rdata = r_q.rd_h;
    assign cpu_rdata = r_q.rd_c;

    // R11: a read of the slot-count word returns it one cycle later
    p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_we && sd[0].rgn == RGN_GLOBAL && sd[0].gok && sd[0].greg == 2'd0)
        |=> (hst_rdata == CNT_WORD));
    // R11: read data holds without a read request
    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_we) |=> $stable(cpu_rdata));
endmodule

// File: tb/mq_mailbox_tb.sv
module mq_mailbox_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 2, NO = 2, EL = 2, WL = 3;
    localparam int ENT = 1 << EL, WRD = 1 << WL;
    localparam logic [31:0] C_CLAIM = 32'h0100_0000, C_PURGE = 32'h0200_0000;
    localparam logic [31:0] C_READY = 32'h0400_0000, C_DISC  = 32'h0800_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_req = 0, hst_we = 0, cpu_req = 0, cpu_we = 0;
    logic [15:0] hst_addr = 0, cpu_addr = 0;
    logic [31:0] hst_wdata = 0, cpu_wdata = 0, hst_rdata, cpu_rdata;
    logic irq_o;

    mq_mailbox #(.N_IN(NI), .N_OUT(NO), .ENTRIES_LOG2(EL), .WORDS_LOG2(WL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_o(irq_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_errors = 0;
    bit done = 0;

    // reference model: slots 0..1 incoming, 2..3 outgoing
    int          m_len [4][$];
    logic [31:0] m_w   [4][$];
    logic [31:0] stage [4][WRD];
    bit          claimed [4];
    logic [31:0] mask_m = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base(input int s);
        return (s < NI) ? 16'(16'h4000 + s * 16'h400) : 16'(16'h8000 + (s - NI) * 16'h400);
    endfunction
    function automatic int prod_side(input int s);
        return (s < NI) ? 0 : 1;
    endfunction

    function automatic logic [31:0] exp_status(input int s);
        int n = m_len[s].size();
        logic [7:0] hl = (n == 0) ? 8'h0 : 8'(m_len[s][0]);
        return {4'(WL), 4'b0, hl, 8'(n), 6'(EL), (n == 0), (n == ENT)};
    endfunction
    function automatic logic [31:0] exp_gstat();
        logic [31:0] v = 0;
        for (int s = 0; s < NI; s++) v[16 + s] = (m_len[s].size() == 0);
        for (int s = 0; s < NO; s++) v[s] = (m_len[NI + s].size() != 0);
        return v;
    endfunction

    task automatic bus(input int side, input bit we, input logic [15:0] addr,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        if (side == 0) begin hst_req = 1; hst_we = we; hst_addr = addr; hst_wdata = wd; end
        else           begin cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; end
        @(negedge clk);
        hst_req = 0; hst_we = 0; cpu_req = 0; cpu_we = 0;
        rd = (side == 0) ? hst_rdata : cpu_rdata;
    endtask

    task automatic check_irq();
        logic exp = |(exp_gstat() & mask_m);
        chk(irq_o === exp, "R10 irq", 32'(irq_o), 32'(exp));
    endtask

    task automatic cmd(input int s, input bit from_prod, input logic [31:0] v);
        logic [31:0] rd;
        int pre = m_len[s].size();
        bit cl, rdy, pg, dc;
        bus(from_prod ? prod_side(s) : 1 - prod_side(s), 1, base(s), v, rd);
        cl = from_prod && v[24]; rdy = from_prod && v[26];
        pg = v[25]; dc = !from_prod && v[27];
        if (pg) begin
            m_len[s].delete(); m_w[s].delete(); claimed[s] = 0;
        end else begin
            if (rdy && claimed[s] && pre != ENT) begin
                m_len[s].push_back(int'(v[7:0]));
                for (int i = 0; i < WRD; i++) m_w[s].push_back(stage[s][i]);
            end
            if (rdy) claimed[s] = 0;
            if (dc && pre != 0) begin
                void'(m_len[s].pop_front());
                for (int i = 0; i < WRD; i++) void'(m_w[s].pop_front());
            end
            if (cl && pre != ENT) claimed[s] = 1;
        end
        check_irq();
    endtask

    task automatic wr_word(input int s, input int i, input logic [31:0] d);
        logic [31:0] rd;
        bus(prod_side(s), 1, base(s) + 16'(8 + 4 * i), d, rd);
        if (m_len[s].size() != ENT) stage[s][i] = d;
        check_irq();
    endtask

    task automatic chk_status(input int s, input int side, input string req);
        logic [31:0] rd;
        bus(side, 0, base(s) + 16'd4, 0, rd);
        chk(rd === exp_status(s), req, rd, exp_status(s));
        check_irq();
    endtask

    task automatic chk_head(input int s, input int n, input string req);
        logic [31:0] rd;
        for (int i = 0; i < n; i++) begin
            bus(1 - prod_side(s), 0, base(s) + 16'(8 + 4 * i), 0, rd);
            chk(rd === m_w[s][i], req, rd, m_w[s][i]);
        end
        check_irq();
    endtask

    task automatic chk_global(input logic [15:0] a, input logic [31:0] exp, input string req);
        logic [31:0] rd;
        bus(0, 0, a, 0, rd);
        chk(rd === exp, req, rd, exp);
        check_irq();
    endtask

    task automatic put_msg(input int s, input int n, input logic [31:0] seed);
        cmd(s, 1, C_CLAIM);
        for (int i = 0; i < n; i++) wr_word(s, i, seed + 32'(i));
        cmd(s, 1, C_READY | 32'(n));
    endtask

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            chk_status(s, 0, "R1 host status");
            chk_status(s, 1, "R1 cpu status");
        end
        chk_global(16'h0004, exp_gstat(), "R9 reset global status");
        chk_global(16'h0000, 32'h0000_0202, "R8 R11 slot count");
        // R2 incoming message host->cpu
        put_msg(0, 5, 32'hA000_0010);
        chk_status(0, 1, "R2 count after commit");
        chk_status(0, 0, "R3 status layout");
        chk_head(0, 5, "R2 R11 payload");
        chk_global(16'h0004, exp_gstat(), "R9 global after commit");
        // R4 ready without claim
        cmd(1, 1, C_READY | 32'd3);
        chk_status(1, 1, "R4 unclaimed ready");
        // R12 fill outgoing slot
        for (int k = 0; k < ENT; k++) put_msg(2, k + 1, 32'hB000_0000 + 32'(k << 8));
        chk_status(2, 0, "R12 full flag");
        // R4 claim on full ignored
        cmd(2, 1, C_CLAIM);
        cmd(2, 0, C_DISC);
        cmd(2, 1, C_READY | 32'd7);
        chk_status(2, 0, "R4 claim while full");
        // R5 ordered drain and discard on empty
        while (m_len[2].size() != 0) begin
            chk_head(2, m_len[2][0], "R5 head order");
            cmd(2, 0, C_DISC);
            chk_status(2, 0, "R5 after discard");
        end
        cmd(2, 0, C_DISC);
        chk_status(2, 0, "R5 discard on empty");
        // R12 wrap
        put_msg(2, 8, 32'hC000_0000);
        chk_head(2, 8, "R12 wrapped payload");
        cmd(2, 0, C_DISC);
        // R6 purge priority
        put_msg(3, 2, 32'hD000_0000);
        cmd(3, 1, C_CLAIM);
        wr_word(3, 0, 32'hDEAD_0001);
        cmd(3, 1, C_PURGE | C_READY | 32'd1);
        chk_status(3, 0, "R6 purge over ready");
        cmd(3, 1, C_READY | 32'd1);
        chk_status(3, 0, "R6 claim dropped by purge");
        put_msg(3, 1, 32'hD100_0000);
        put_msg(3, 1, 32'hD200_0000);
        cmd(3, 0, C_PURGE | C_DISC);
        chk_status(3, 1, "R6 consumer purge");
        // R7 consumer-side claim/ready ignored, producer discard ignored
        cmd(0, 0, C_CLAIM);
        cmd(0, 0, C_READY | 32'd2);
        cmd(0, 1, C_DISC);
        chk_status(0, 1, "R7 side filtering");
        chk_head(0, 5, "R7 payload kept");
        // R10 mask
        bus(0, 1, 16'h0008, 32'hFFFF_FFFF, rd);
        mask_m = 32'h0003_0003;
        check_irq();
        chk_global(16'h0008, 32'h0003_0003, "R10 mask readback");
        bus(0, 1, 16'h0008, 32'h0000_0002, rd);
        mask_m = 32'h0000_0002;
        check_irq();
        put_msg(3, 1, 32'hE000_0000);
        chk_status(3, 0, "R10 slot3 loaded");
        cmd(3, 0, C_DISC);
        chk_global(16'h0004, exp_gstat(), "R9 final global status");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule